// File: doc/BRIEF.md
# Push-Button Lockout Debouncer

This block cleans up the signal from a single mechanical push-button wired active low: the line idles high through a pull-up and the button grounds it when pressed. Contact chatter lasts roughly 1 to 10 ms and throws a burst of edges in both directions. Instead of waiting for the line to settle before it believes anything, this debouncer acts on the very first falling edge it sees. It emits a one-cycle press pulse at once and then goes deaf to the pin for a fixed lockout window, about 20 ms by default.

When the lockout ends, the block samples the synchronized pin once more. If that level disagrees with the debounced level, the debounced level follows it and a fresh lockout starts. A press pulse is emitted only when that update is high-to-low. A release is tracked the same way: it drops the debounced level back high and starts a lockout, but it never produces a pulse. The raw pin first passes through a two-flop synchronizer.

The block has no data stream, so it has no valid/ready handshake. All pins are plain control signals: a clock, a synchronous reset, the raw pin, the debounced level and the press strobe.

Top module: `btn_lockout_debounce`

## Requirements
- R1: While reset is high and in the cycle after it, `level_o` is 1 (idle, released) and `press_o` is 0.
- R2: The raw pin passes through two synchronizer flops. A raw low that is first sampled at clock edge k, with the block idle, makes `press_o` high and `level_o` low just after edge k+2, and not before.
- R3: `press_o` is never high for two cycles in a row.
- R4: `press_o` is high exactly in the cycle in which `level_o` has just fallen from 1 to 0. It is never high while `level_o` is 1.
- R5: After any change of `level_o`, `level_o` holds for at least LOCK_CYCLES clock cycles. Edges on the pin during that window have no effect. LOCK_CYCLES = CLK_HZ/1000 * LOCK_MS.
- R6: A release (the debounced level rising while held low) produces no press pulse and starts a lockout.
- R7: At the end of a lockout, a synchronized level that differs from `level_o` is copied into `level_o` and starts another lockout. If that copy is a fall, it also raises `press_o` for one cycle.
- R8: A low pulse on the pin that is shorter than the lockout gives exactly one press pulse. `level_o` then returns to 1 at the end of that lockout, LOCK_CYCLES edges after the press, with no further pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_n_i | input | 1 | Raw button pin, asynchronous, low when pressed |
| level_o | output | 1 | Debounced pin level, 1 = released |
| press_o | output | 1 | One-cycle strobe on an accepted press |

## Verification
The bench attacks the bounce bursts on both press and release. A design without a working lockout would count each chatter edge as a new press, and one that looked at both edges without blanking would also pulse on release. It also covers a short tap that ends inside the lockout, where a design that skipped the end-of-lockout check would leave the level stuck low. It covers a new press that arrives during the release lockout, where the same omission would lose the press entirely. Exact cycle checks on the first pulse catch a missing or extra synchronizer stage and an off-by-one lockout length.

// File: rtl/btn_lockout_pkg.sv
package btn_lockout_pkg;
  typedef enum logic [1:0] {
    S_IDLE_HI = 2'd0,
    S_LOCKOUT = 2'd1,
    S_HELD_LO = 2'd2
  } dbn_state_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= {STAGES{RESET_VAL}};
    else       chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
  parameter int LOCK_CYCLES = 40,
  localparam int CW = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= CW'(LOCK_CYCLES - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import btn_lockout_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic sync_i,
  input  logic expire_i,
  output logic start_o,
  output logic level_o,
  output logic press_o
);
  dbn_state_e state_q;
  logic       level_q;
  logic       press_q;
  logic       differ;

  assign differ = (sync_i != level_q);

  always_comb begin
    unique case (state_q)
      S_IDLE_HI: start_o = !sync_i;
      S_HELD_LO: start_o = sync_i;
      S_LOCKOUT: start_o = expire_i && differ;
      default:   start_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= S_IDLE_HI;
      level_q <= 1'b1;
      press_q <= 1'b0;
    end else begin
      press_q <= 1'b0;
      unique case (state_q)
        S_IDLE_HI: if (!sync_i) begin
          level_q <= 1'b0;
          press_q <= 1'b1;
          state_q <= S_LOCKOUT;
        end
        S_HELD_LO: if (sync_i) begin
          level_q <= 1'b1;
          state_q <= S_LOCKOUT;
        end
        S_LOCKOUT: if (expire_i) begin
          if (differ) begin
            level_q <= sync_i;
            press_q <= !sync_i;
          end else begin
            state_q <= level_q ? S_IDLE_HI : S_HELD_LO;
          end
        end
        default: state_q <= S_IDLE_HI;
      endcase
    end
  end

  assign level_o = level_q;
  assign press_o = press_q;
endmodule

// File: rtl/btn_lockout_debounce.sv
module btn_lockout_debounce #(
  parameter int CLK_HZ  = 125_000_000,
  parameter int LOCK_MS = 20,
  localparam int LOCK_CYCLES = (CLK_HZ / 1000) * LOCK_MS
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic btn_n_i,
  output logic level_o,
  output logic press_o
);
  logic sync_lvl;
  logic tmr_start;
  logic tmr_expire;

  btn_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (btn_n_i),
    .q_o   (sync_lvl)
  );

  lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (tmr_start),
    .expire_o (tmr_expire)
  );

  lock_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .sync_i   (sync_lvl),
    .expire_i (tmr_expire),
    .start_o  (tmr_start),
    .level_o  (level_o),
    .press_o  (press_o)
  );
endmodule

// File: rtl/btn_lockout_checker.sv
module btn_lockout_checker #(
  parameter int LOCK_CYCLES = 40,
  localparam int GW = $clog2(LOCK_CYCLES + 1)
) (
  input logic clk_i,
  input logic rst_i,
  input logic level_o,
  input logic press_o
);
  logic [GW-1:0] gap_q;
  logic          prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gap_q  <= GW'(LOCK_CYCLES);
      prev_q <= 1'b1;
    end else begin
      prev_q <= level_o;
      if (level_o != prev_q)            gap_q <= GW'(1);
      else if (gap_q != GW'(LOCK_CYCLES)) gap_q <= gap_q + 1'b1;
      if (level_o != prev_q)
        p_lockout_hold_r5: assert (gap_q >= GW'(LOCK_CYCLES))
          else $error("level changed %0d cycles after previous change", gap_q);
    end
  end

  p_reset_state_r1: assert property (@(posedge clk_i)
    rst_i |=> (level_o && !press_o));

  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    press_o |=> !press_o);

  p_pulse_low_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    press_o |-> !level_o);

  p_fall_pulses_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(level_o) |-> press_o);

  p_release_silent_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(level_o) |-> !press_o);
endmodule

bind btn_lockout_debounce btn_lockout_checker #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .level_o (level_o),
  .press_o (press_o)
);

// File: tb/tb_btn_lockout_debounce.sv
`timescale 1ns/1ps
module tb_btn_lockout_debounce;
  localparam int CLK_HZ  = 10_000;
  localparam int LOCK_MS = 4;
  localparam int L       = (CLK_HZ / 1000) * LOCK_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_n = 1'b1;
  logic level, press;
  int   checks = 0;
  int   fails = 0;
  int   pulses = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  btn_lockout_debounce #(.CLK_HZ(CLK_HZ), .LOCK_MS(LOCK_MS)) dut (
    .clk_i (clk), .rst_i (rst), .btn_n_i (btn_n),
    .level_o (level), .press_o (press)
  );

  always @(posedge clk) if (!rst && press) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; btn_n = 1'b1;
    negs(3);
    chk("R1 level in reset", level, 1);
    chk("R1 press in reset", press, 0);
    rst = 1'b0;
    negs(1);
    chk("R1 level after reset", level, 1);
    chk("R1 press after reset", press, 0);
  endtask

  task automatic t_clean_press;
    int p0 = pulses;
    btn_n = 1'b0;
    negs(2);
    chk("R2 no early press", press, 0);
    chk("R2 no early level", level, 1);
    negs(1);
    chk("R2 press timing", press, 1);
    chk("R2 level low", level, 0);
    negs(1);
    chk("R3 pulse one cycle", press, 0);
    negs(2 * L);
    chk("R4 one pulse for clean press", pulses - p0, 1);
    btn_n = 1'b1;
    negs(3);
    chk("R6 release level", level, 1);
    negs(L + 5);
    chk("R6 release silent", pulses - p0, 1);
  endtask

  task automatic t_bounce;
    int p0 = pulses;
    int bad = 0;
    btn_n = 1'b0;
    negs(3);
    for (int i = 0; i < 10; i++) begin
      btn_n = ~btn_n;
      negs(3);
      if (level != 0) bad++;
    end
    btn_n = 1'b0;
    negs(L);
    chk("R5 level held through bounce", bad, 0);
    chk("R5 one pulse for bouncy press", pulses - p0, 1);
    chk("R5 level settled low", level, 0);
    btn_n = 1'b1;
    negs(3);
    for (int i = 0; i < 10; i++) begin
      btn_n = ~btn_n;
      negs(3);
      if (level != 1) bad++;
    end
    btn_n = 1'b1;
    negs(L + 5);
    chk("R6 level held through release bounce", bad, 0);
    chk("R6 no pulse on bouncy release", pulses - p0, 1);
    chk("R6 level settled high", level, 1);
  endtask

  task automatic t_short_tap;
    int p0 = pulses;
    btn_n = 1'b0;
    negs(5);
    btn_n = 1'b1;
    negs(L + 2 - 5);
    chk("R8 level low until lockout end", level, 0);
    negs(1);
    chk("R8 level back high at lockout end", level, 1);
    chk("R7 no pulse on rise", press, 0);
    negs(L + 5);
    chk("R8 single pulse for tap", pulses - p0, 1);
    chk("R8 level idle", level, 1);
  endtask

  task automatic t_press_in_release_lock;
    int p0 = pulses;
    btn_n = 1'b0;
    negs(L + 10);
    btn_n = 1'b1;
    negs(3);
    chk("R6 released", level, 1);
    negs(7);
    btn_n = 1'b0;
    negs(L - 8);
    chk("R5 new press blanked", level, 1);
    negs(1);
    chk("R7 press at lockout end", press, 1);
    chk("R7 level low at lockout end", level, 0);
    negs(1);
    chk("R3 pulse one cycle again", press, 0);
    chk("R7 total pulses", pulses - p0, 2);
    btn_n = 1'b1;
    negs(2 * L + 5);
  endtask

  initial begin
    t_reset();
    t_clean_press();
    t_bounce();
    t_short_tap();
    t_press_in_release_lock();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule